// File: doc/BRIEF.md
# Multi-stream bulk-IN bridge scheduler

This block feeds an external USB 3.0 bridge chip through its synchronous parallel slave port. Several on-chip stream FIFOs, each presenting its head word and a non-empty flag, share the port. Every stream is bound to one bulk-IN buffer inside the bridge, and the buffer address equals the stream index. The scheduler picks a stream, drives that buffer address, waits until the bridge's full flag can be trusted, and then writes one word per cycle while the flag stays low.

The host posts transfers of a fixed byte length for each stream, given on `xfer_bytes`. The scheduler counts the bytes of the current transfer for each stream. A transfer whose length is not a whole number of packets is closed by raising the packet-end strobe together with its last word, so the bridge is never given more bytes than the host buffer holds. A transfer whose length is a whole number of packets is closed by a zero-length packet, which is the strobe raised with no data. After that the stream stays silent for a guard time, which avoids a known payload-corruption hazard in the bridge. Streams are served round-robin, one packet per grant.

Top module: `usb_bulk_in_sched`

## Requirements
- R1: While `ep_wr` is high, `ep_data` is the head word of the stream whose index is on `ep_sel`. `src_take` is the one-hot of that index in the same cycle and zero otherwise. Each stream's words reach the bridge in FIFO order.
- R2: A write or packet-end strobe happens at least FLAG_LAT cycles after `ep_sel` last changed. No word is written while `ep_full` is high. A stream whose buffer reads full after settling is skipped, and the other streams keep being served.
- R3: `ep_sel` changes only at a packet boundary of the stream that was selected, which is a byte count that is a multiple of PKT_BYTES.
- R4: No transfer gets more than `xfer_bytes` bytes. When the length is not a multiple of PKT_BYTES, `ep_commit` is high together with the transfer's last word. Lengths are multiples of DW/8 bytes and at least DW/8.
- R5: When the length is a multiple of PKT_BYTES, `ep_commit` never rises with data. After the last full packet, the next event on that stream is a zero-length packet: `ep_commit` high while `ep_wr` is low.
- R6: After a zero-length packet on a stream, that stream sees no write and no strobe for GUARD cycles.
- R7: Grants go round-robin. When all streams are eligible, successive packets come from streams 0, 1, 2, ... in index order, wrapping around. The first grant after reset goes to stream 0.
- R8: During reset `ep_wr`, `ep_commit` and `src_take` are low and `ep_sel` is 0.
- R9: The byte count restarts at every transfer close, so back-to-back transfers of the same stream each carry exactly `xfer_bytes` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, at most 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| src_avail | input | NS | Per-stream FIFO non-empty |
| src_word | input | NS*DW | Per-stream FIFO head words, stream s at bits s*DW |
| src_take | output | NS | Per-stream FIFO pop |
| xfer_bytes | input | NS*LW | Per-stream host transfer length in bytes |
| ep_sel | output | AW | Bridge buffer address (stream index) |
| ep_full | input | 1 | Full flag of the addressed buffer, FLAG_LAT cycles behind `ep_sel` |
| ep_wr | output | 1 | Write strobe |
| ep_data | output | DW | Write data |
| ep_commit | output | 1 | Packet-end strobe |

## Verification
A wrong per-stream byte count shows up at the transfer's close. The strobe falls on the wrong word, a zero-length packet goes missing or comes uninvited, or a transfer runs past its length. The bridge model flags each of these on the cycle of the offending write. A wrong grant or a selection changed too early shows up within a packet, as data from the wrong stream, a word out of FIFO order, or a write before the flag has settled. A guard counter that was loaded wrongly shows up as a write to the silenced stream inside its window. A stuck grant shows up as a stream that makes no progress over a phase.

// File: rtl/usb_bulk_in_sched.sv
module usb_bulk_in_sched #(
  parameter int NS        = 4,
  parameter int DW        = 32,
  parameter int LW        = 16,
  parameter int PKT_BYTES = 1024,
  parameter int GUARD     = 12500,
  parameter int FLAG_LAT  = 2,
  localparam int AW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int BPW = DW / 8,
  localparam int PB  = $clog2(PKT_BYTES),
  localparam int GW  = $clog2(GUARD + 1),
  localparam int SW  = $clog2(FLAG_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    src_avail,
  input  logic [NS*DW-1:0] src_word,
  output logic [NS-1:0]    src_take,
  input  logic [NS*LW-1:0] xfer_bytes,
  output logic [AW-1:0]    ep_sel,
  input  logic             ep_full,
  output logic             ep_wr,
  output logic [DW-1:0]    ep_data,
  output logic             ep_commit
);

  typedef enum logic [1:0] {IDLE, SETTLE, MOVE} st_t;

  st_t           st;
  logic [AW-1:0] gnt, last, pick;
  logic [SW-1:0] wait_cnt;
  logic [LW-1:0] bcnt  [NS];
  logic [GW-1:0] guard [NS];
  logic [NS-1:0] zlp_pend, elig;
  logic          any, settled, last_w, pkt_done;
  logic [LW-1:0] len_g;
  logic [LW:0]   nb;

  always_comb
    for (int i = 0; i < NS; i++)
      elig[i] = (guard[i] == '0) && (zlp_pend[i] || src_avail[i]);

  always_comb begin
    any  = 1'b0;
    pick = last;
    for (int k = 1; k <= NS; k++)
      if (!any && elig[(int'(last) + k) % NS]) begin
        any  = 1'b1;
        pick = AW'((int'(last) + k) % NS);
      end
  end

  assign settled  = (st == SETTLE) && (wait_cnt == SW'(FLAG_LAT));
  assign len_g    = xfer_bytes[gnt*LW +: LW];
  assign nb       = {1'b0, bcnt[gnt]} + (LW+1)'(BPW);
  assign last_w   = nb >= {1'b0, len_g};
  assign pkt_done = nb[PB-1:0] == '0;

  assign ep_sel    = gnt;
  assign ep_wr     = (st == MOVE) && src_avail[gnt] && !ep_full;
  assign ep_data   = src_word[gnt*DW +: DW];
  assign ep_commit = (ep_wr && last_w && !pkt_done) ||
                     (settled && !ep_full && zlp_pend[gnt]);
  assign src_take  = ep_wr ? (NS'(1) << gnt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      gnt      <= '0;
      last     <= AW'(NS - 1);
      wait_cnt <= '0;
      zlp_pend <= '0;
      for (int i = 0; i < NS; i++) begin
        bcnt[i]  <= '0;
        guard[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NS; i++)
        if (guard[i] != '0) guard[i] <= guard[i] - 1'b1;
      case (st)
        IDLE:
          if (any) begin
            gnt      <= pick;
            wait_cnt <= '0;
            st       <= SETTLE;
          end
        SETTLE:
          if (!settled) wait_cnt <= wait_cnt + 1'b1;
          else if (ep_full) begin
            last <= gnt;
            st   <= IDLE;
          end else if (zlp_pend[gnt]) begin
            zlp_pend[gnt] <= 1'b0;
            guard[gnt]    <= GW'(GUARD);
            last          <= gnt;
            st            <= IDLE;
          end else st <= MOVE;
        MOVE:
          if (ep_wr) begin
            if (last_w) begin
              bcnt[gnt] <= '0;
              if (pkt_done) zlp_pend[gnt] <= 1'b1;
              last <= gnt;
              st   <= IDLE;
            end else begin
              bcnt[gnt] <= nb[LW-1:0];
              if (pkt_done) begin
                last <= gnt;
                st   <= IDLE;
              end
            end
          end
        default: st <= IDLE;
      endcase
    end
  end

  p_flag_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MOVE && $past(st) == SETTLE) |-> $past(wait_cnt) == SW'(FLAG_LAT));

  p_sel_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MOVE) |-> $stable(ep_sel));

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ep_wr |-> ({1'b0, bcnt[gnt]} < {1'b0, len_g}));

  p_zlp_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_commit && !ep_wr) |-> (bcnt[gnt] == '0));

  p_guard_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_commit && !ep_wr) |=> (guard[$past(gnt)] == GW'(GUARD)));

  p_guard_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_wr || ep_commit) |-> (guard[gnt] == '0));

endmodule

// File: tb/sim_usb_bulk_in_sched.sv
module sim_usb_bulk_in_sched;
  timeunit 1ns; timeprecision 1ps;

  localparam int NS = 3, DW = 32, LW = 16, PKT = 64, GUARD = 40, FL = 2, SLOTS = 2;
  localparam int AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0]    src_avail = '0;
  logic [NS*DW-1:0] src_word = '0;
  logic [NS-1:0]    src_take;
  logic [NS*LW-1:0] xfer_bytes = '0;
  logic [AW-1:0]    ep_sel;
  logic             ep_full = 1'b0;
  logic             ep_wr, ep_commit;
  logic [DW-1:0]    ep_data;

  always #2 clk = ~clk;

  usb_bulk_in_sched #(.NS(NS), .DW(DW), .LW(LW), .PKT_BYTES(PKT), .GUARD(GUARD), .FLAG_LAT(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .src_avail(src_avail), .src_word(src_word), .src_take(src_take),
    .xfer_bytes(xfer_bytes), .ep_sel(ep_sel), .ep_full(ep_full), .ep_wr(ep_wr),
    .ep_data(ep_data), .ep_commit(ep_commit));

  int total = 0, fails = 0;
  int lens [NS];
  int seq_src [NS], seq_rx [NS], xb [NS], zexp [NS], zcyc [NS], slots [NS], done_x [NS], wcnt [NS];
  int cyc, acnt, prev_addr, last_served;
  int valid_pct, drain_pct;
  bit rr_mode, block0, run = 0;
  logic [FL-1:0] fp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int s, input int n);
    return {8'(s), 24'(n)};
  endfunction

  always @(negedge clk) if (run) begin
    bit wr, cm, fl;
    int a;
    logic [DW-1:0] d;
    logic [NS-1:0] tk;
    wr = ep_wr; cm = ep_commit; fl = ep_full; a = int'(ep_sel); d = ep_data; tk = src_take;
    cyc++;
    if (a != prev_addr) begin
      chk(xb[prev_addr] % PKT == 0, "R3", "bytes into packet at select change", xb[prev_addr] % PKT, 0);
      acnt = 0;
    end else acnt++;
    prev_addr = a;
    if (wr || cm) begin
      chk(acnt >= FL, "R2", "cycles since select", acnt, FL);
      chk(cyc - zcyc[a] > GUARD, "R6", "cycles since zero-length packet", cyc - zcyc[a], GUARD + 1);
    end
    if (wr) begin
      wcnt[a]++;
      chk(!fl, "R2", "write while full", int'(fl), 0);
      chk(tk == (NS'(1) << a), "R1", "pop vector", int'(tk), 1 << a);
      chk(d == word_of(a, seq_rx[a]), "R1", "data word", int'(d), int'(word_of(a, seq_rx[a])));
      chk(zexp[a] == 0, "R5", "data before zero-length packet", 1, 0);
      seq_rx[a]++;
      if (xb[a] % PKT == 0) begin
        if (rr_mode && last_served >= 0)
          chk(a == (last_served + 1) % NS, "R7", "packet stream", a, (last_served + 1) % NS);
        last_served = a;
      end
      xb[a] += 4;
      chk(xb[a] <= lens[a], "R4", "transfer bytes", xb[a], lens[a]);
      if (cm) begin
        chk(xb[a] == lens[a], "R4", "bytes at packet end", xb[a], lens[a]);
        chk(lens[a] % PKT != 0, "R5", "strobe with data on whole-packet length", lens[a] % PKT, 1);
        slots[a]++; xb[a] = 0; done_x[a]++;
      end else if (xb[a] % PKT == 0) begin
        slots[a]++;
        if (xb[a] == lens[a]) begin zexp[a] = 1; xb[a] = 0; end
      end
      chk(slots[a] <= SLOTS, "R2", "bridge slots used", slots[a], SLOTS);
    end else if (cm) begin
      chk(zexp[a] == 1, "R5", "zero-length packet expected", zexp[a], 1);
      zexp[a] = 0; zcyc[a] = cyc; slots[a]++; done_x[a]++;
      chk(slots[a] <= SLOTS, "R2", "bridge slots used", slots[a], SLOTS);
    end
    for (int s = 0; s < NS; s++) begin
      if (!(block0 && s == 0) && slots[s] > 0 && int'($urandom % 100) < drain_pct) slots[s]--;
      if (tk[s]) seq_src[s]++;
      if (tk[s] || !src_avail[s]) src_avail[s] = int'($urandom % 100) < valid_pct;
      src_word[s*DW +: DW] = word_of(s, seq_src[s]);
    end
    fp = {fp[FL-2:0], slots[a] >= SLOTS};
    ep_full = fp[FL-1];
  end

  task automatic phase(input int l0, input int l1, input int l2, input int vp, input int dp,
                       input bit rr, input bit blk, input int ncyc);
    run = 0;
    @(negedge clk);
    rst_n = 1'b0;
    lens[0] = l0; lens[1] = l1; lens[2] = l2;
    for (int s = 0; s < NS; s++) begin
      xfer_bytes[s*LW +: LW] = LW'(lens[s]);
      seq_src[s] = 0; seq_rx[s] = 0; xb[s] = 0; zexp[s] = 0; zcyc[s] = -1000000;
      slots[s] = 0; done_x[s] = 0; wcnt[s] = 0;
      src_word[s*DW +: DW] = word_of(s, 0);
    end
    src_avail = '0; ep_full = 1'b0; fp = '0;
    cyc = 0; acnt = 0; prev_addr = 0; last_served = -1;
    valid_pct = vp; drain_pct = dp; rr_mode = rr; block0 = blk;
    repeat (3) @(negedge clk);
    chk(ep_wr == 0 && ep_commit == 0, "R8", "strobes in reset", int'({ep_wr, ep_commit}), 0);
    chk(src_take == 0, "R8", "pops in reset", int'(src_take), 0);
    chk(ep_sel == 0, "R8", "select in reset", int'(ep_sel), 0);
    rst_n = 1'b1;
    run = 1;
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    phase(200, 100, 60, 100, 100, 1'b1, 1'b0, 600);
    for (int s = 0; s < NS; s++) chk(done_x[s] >= 2, "R7", "transfers per stream", done_x[s], 2);
    phase(256, 72, 128, 70, 25, 1'b0, 1'b0, 20000);
    for (int s = 0; s < NS; s++) chk(done_x[s] >= 2, "R9", "transfers closed", done_x[s], 2);
    phase(64, 64, 64, 100, 50, 1'b0, 1'b1, 3000);
    chk(slots[0] == SLOTS, "R2", "blocked buffer stays full", slots[0], SLOTS);
    chk(wcnt[0] <= 16 * SLOTS, "R2", "words into blocked buffer", wcnt[0], 16 * SLOTS);
    chk(wcnt[1] > 100, "R2", "stream 1 served past blocked buffer", wcnt[1], 101);
    chk(wcnt[2] > 100, "R2", "stream 2 served past blocked buffer", wcnt[2], 101);
    run = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule